// File: doc/BRIEF.md
# Multi-Channel Reload Timer Unit

This block groups two or three independent reload down-counters behind one byte-addressed register window. Each counter has its own reload value, live count, control word and interrupt line. The third channel also has a capture register and capture control bits, and a build parameter decides whether it exists. A shared run register has one bit per channel, so software can start or halt each counter on its own. An optional output-control register stores a single bit.

Each channel counts down on a tick from its own prescaler, which divides the clock by 4, 16, 64, 256 or 1024. When a tick arrives while the count is zero, the channel reloads the count and raises an underflow flag. The channel interrupt is that flag gated by an enable bit. The bus port is synchronous: read data and the access-error pulse are both registered and appear in the cycle after the request. Offsets that decode to nothing read as zero and pulse the error output.

Top module: `tmr_unit`

## Requirements
- R1: After reset, every reload and count register reads 0xFFFFFFFF. Every control register, the run register and the output-control register read 0. All interrupt outputs are 0.
- R2: The address map is fixed. 0x00 is output control and 0x04 is run. Channel 0 uses 0x08, 0x0C and 0x10, channel 1 uses 0x14, 0x18 and 0x1C, and channel 2 uses 0x20, 0x24, 0x28 and 0x2C. Within a window the order is reload, count, control, then capture (channel 2 only).
- R3: Run bit n enables channel n. A read of the run register returns the channel bits last written.
- R4: Control bits [2:0] select the prescale. Values 0 to 4 give one count tick every 4^(sel+1) running cycles. Values 5 to 7 give no ticks. Writing the count or control register restarts the prescale phase.
- R5: A tick at count zero reloads the count from the reload register and sets control bit 8, the underflow flag. The channel interrupt output is high, one cycle later, while bit 8 and bit 5 (the interrupt enable) are both set.
- R6: Writing control bit 8 as 0 clears the underflow flag. Writing it as 1 leaves the flag unchanged.
- R7: While a run bit is clear, the count of that channel holds its value. Setting the bit again resumes counting from that value without a reload, and the prescale phase carries on from where it stopped.
- R8: Only channel 2 stores control bits [7:6] and has a capture register. Channels 0 and 1 store control bits 0 to 2 and 5 only.
- R9: When the output-control register is present, it stores only bit 0.
- R10: An access to an unaligned offset, an unmapped offset, the output-control offset when that register is absent, or any offset at or above 0x20 without channel 2 reads as zero and pulses err for one cycle.
- R11: Without channel 2, a write that sets run bit 2 pulses err. Bits 0 and 1 are still stored.
- R12: rdata carries the addressed value in the cycle after rd_en and is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read request for this cycle |
| wr_en | input | 1 | Write request for this cycle |
| addr | input | AW | Byte offset of the access |
| wdata | input | DW | Write data |
| rdata | output | DW | Registered read data |
| err | output | 1 | One-cycle pulse after a bad access |
| irq | output | 3 | Per-channel interrupt; bit 2 is 0 without channel 2 |

## Verification
The bench builds two copies side by side on one bus. One copy has the third channel and the output-control register. The other has neither, and it is the only way to reach the missing-channel errors, the refused run bit 2 and the absent offset 0x00. The full copy covers capture storage, the masking of control bits per channel, and the stored output-control bit. Both copies use the default 32-bit data width, so the reset value of all ones and the counter reload are seen at full width.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    REG_RELOAD = 2'd0,
    REG_COUNT  = 2'd1,
    REG_CTRL   = 2'd2,
    REG_CAPT   = 2'd3
  } chan_reg_e;

  typedef struct packed {
    logic      hit_outctl;
    logic      hit_start;
    logic      hit_chan;
    logic [1:0] chan;
    chan_reg_e rsel;
    logic      bad;
  } dec_s;

  localparam int CAP_CH      = 2;
  localparam int OUTCTL_OFS  = 0;
  localparam int START_OFS   = 4;
  localparam int FLAG_BIT    = 8;
  localparam int IE_BIT      = 5;
  localparam int CTRL_W      = 8;
  localparam logic [CTRL_W-1:0] CTRL_MASK_BASE = 8'h27;
  localparam logic [CTRL_W-1:0] CTRL_MASK_CAP  = 8'hE7;

  function automatic int chan_base(input int i);
    return 8 + 12 * i;
  endfunction

  function automatic int chan_nregs(input int i);
    return (i == CAP_CH) ? 4 : 3;
  endfunction

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
  import tmr_pkg::*;
#(
  parameter int AW         = 8,
  parameter int NUM_CH     = 3,
  parameter bit HAS_OUTCTL = 1'b1
) (
  input  logic [AW-1:0] addr,
  output dec_s          dec
);

  logic [AW-1:0] off;

  always_comb begin
    dec = '0;
    off = '0;
    if (addr[1:0] != 2'b00) begin
      dec.bad = 1'b1;
    end else if (addr == AW'(OUTCTL_OFS)) begin
      if (HAS_OUTCTL) dec.hit_outctl = 1'b1;
      else            dec.bad        = 1'b1;
    end else if (addr == AW'(START_OFS)) begin
      dec.hit_start = 1'b1;
    end else begin
      dec.bad = 1'b1;
      for (int i = 0; i < NUM_CH; i++) begin
        if (addr >= AW'(chan_base(i)) &&
            addr <  AW'(chan_base(i) + 4 * chan_nregs(i))) begin
          off          = addr - AW'(chan_base(i));
          dec.bad      = 1'b0;
          dec.hit_chan = 1'b1;
          dec.chan     = 2'(i);
          dec.rsel     = chan_reg_e'(off[3:2]);
        end
      end
    end
  end

endmodule

// File: rtl/tmr_presc.sv
module tmr_presc #(
  parameter int MAX_SEL = 4,
  parameter int SEL_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  localparam int PW = 2 * (MAX_SEL + 1);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] mask;
  logic          sel_ok;

  always_comb begin
    mask = '0;
    for (int k = 0; k <= MAX_SEL; k++) begin
      if (int'(sel) >= k) mask[2*k +: 2] = 2'b11;
    end
  end

  assign sel_ok = (int'(sel) <= MAX_SEL);
  assign tick   = run && sel_ok && ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || clr)  pre_q <= '0;
    else if (run)    pre_q <= pre_q + 1'b1;
  end

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int DW      = 32,
  parameter bit HAS_CAP = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  chan_reg_e     rsel,
  input  logic [DW-1:0] wdata,
  input  logic          run,
  output logic [DW-1:0] rval,
  output logic          irq,
  output logic [DW-1:0] cnt
);

  localparam logic [CTRL_W-1:0] CMASK = HAS_CAP ? CTRL_MASK_CAP : CTRL_MASK_BASE;

  logic [DW-1:0]     reload_q;
  logic [DW-1:0]     cnt_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              flag_q;
  logic              irq_q;
  logic [DW-1:0]     capt_v;
  logic              wr_reload, wr_cnt, wr_ctrl, wr_capt;
  logic              tick;
  logic              at_zero;

  assign wr_reload = we && (rsel == REG_RELOAD);
  assign wr_cnt    = we && (rsel == REG_COUNT);
  assign wr_ctrl   = we && (rsel == REG_CTRL);
  assign wr_capt   = we && (rsel == REG_CAPT);
  assign at_zero   = (cnt_q == '0);

  tmr_presc #(.MAX_SEL(4), .SEL_W(3)) u_presc (
    .clk  (clk),
    .rst  (rst),
    .clr  (wr_cnt || wr_ctrl),
    .run  (run),
    .sel  (ctrl_q[2:0]),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '1;
      cnt_q    <= '1;
      ctrl_q   <= '0;
      flag_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_reload) reload_q <= wdata;
      if (wr_cnt)            cnt_q <= wdata;
      else if (tick)         cnt_q <= at_zero ? reload_q : cnt_q - 1'b1;
      if (wr_ctrl) ctrl_q <= wdata[CTRL_W-1:0] & CMASK;
      if (tick && at_zero)                flag_q <= 1'b1;
      else if (wr_ctrl && !wdata[FLAG_BIT]) flag_q <= 1'b0;
      irq_q <= flag_q && ctrl_q[IE_BIT];
    end
  end

  generate
    if (HAS_CAP) begin : g_capt
      logic [DW-1:0] capt_q;
      always_ff @(posedge clk) begin
        if (rst)          capt_q <= '0;
        else if (wr_capt) capt_q <= wdata;
      end
      assign capt_v = capt_q;
    end else begin : g_no_capt
      logic unused_capt;
      assign unused_capt = wr_capt;
      assign capt_v = '0;
    end
  endgenerate

  always_comb begin
    unique case (rsel)
      REG_RELOAD: rval = reload_q;
      REG_COUNT:  rval = cnt_q;
      REG_CTRL:   rval = DW'({flag_q, ctrl_q});
      default:    rval = capt_v;
    endcase
  end

  assign irq = irq_q;
  assign cnt = cnt_q;

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int AW         = 8,
  parameter int DW         = 32,
  parameter bit HAS_CH2    = 1'b1,
  parameter bit HAS_OUTCTL = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          err,
  output logic [2:0]    irq
);

  localparam int NUM_CH = HAS_CH2 ? 3 : 2;

  dec_s                 dec;
  logic [NUM_CH-1:0]    start_q;
  logic [NUM_CH-1:0]    irq_v;
  logic [DW-1:0]        rv [NUM_CH];
  logic [NUM_CH*DW-1:0] cnt_all;
  logic [DW-1:0]        rd_mux;
  logic                 outctl_v;
  logic                 bad_start;
  logic [DW-1:0]        rdata_q;
  logic                 err_q;

  tmr_decode #(.AW(AW), .NUM_CH(NUM_CH), .HAS_OUTCTL(HAS_OUTCTL)) u_dec (
    .addr (addr),
    .dec  (dec)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      tmr_chan #(.DW(DW), .HAS_CAP(i == CAP_CH)) u_chan (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en && dec.hit_chan && (dec.chan == 2'(i))),
        .rsel  (dec.rsel),
        .wdata (wdata),
        .run   (start_q[i]),
        .rval  (rv[i]),
        .irq   (irq_v[i]),
        .cnt   (cnt_all[i*DW +: DW])
      );
    end

    if (HAS_OUTCTL) begin : g_outctl
      logic outctl_q;
      always_ff @(posedge clk) begin
        if (rst)                         outctl_q <= 1'b0;
        else if (wr_en && dec.hit_outctl) outctl_q <= wdata[0];
      end
      assign outctl_v = outctl_q;
    end else begin : g_no_outctl
      assign outctl_v = 1'b0;
    end

    if (HAS_CH2) begin : g_start_ok
      assign bad_start = 1'b0;
    end else begin : g_start_chk
      assign bad_start = wr_en && dec.hit_start && wdata[CAP_CH];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                         start_q <= '0;
    else if (wr_en && dec.hit_start) start_q <= wdata[NUM_CH-1:0];
  end

  always_comb begin
    rd_mux = '0;
    if (dec.hit_start)       rd_mux = DW'(start_q);
    else if (dec.hit_outctl) rd_mux = DW'(outctl_v);
    else if (dec.hit_chan) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (dec.chan == 2'(i)) rd_mux = rv[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= (rd_en && !dec.bad) ? rd_mux : '0;
      err_q   <= ((rd_en || wr_en) && dec.bad) || bad_start;
    end
  end

  assign rdata = rdata_q;
  assign err   = err_q;
  assign irq   = 3'(irq_v);

endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
  parameter int NUM_CH = 3,
  parameter int DW     = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 rd_en,
  input logic                 wr_en,
  input logic                 err,
  input logic [DW-1:0]        rdata,
  input logic [NUM_CH-1:0]    run,
  input logic [NUM_CH*DW-1:0] cnt_all
);

  p_rdata_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0));

  p_err_after_access_r10: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(rd_en || wr_en));

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_p
      p_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        (!run[i] && !wr_en) |=> $stable(cnt_all[i*DW +: DW]));

      p_step_r4: assert property (@(posedge clk) disable iff (rst)
        (run[i] && !wr_en) |=>
          (cnt_all[i*DW +: DW] == $past(cnt_all[i*DW +: DW])) ||
          (cnt_all[i*DW +: DW] == $past(cnt_all[i*DW +: DW]) - 1'b1) ||
          ($past(cnt_all[i*DW +: DW]) == '0));
    end
  endgenerate

endmodule

bind tmr_unit tmr_unit_chk #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .rd_en   (rd_en),
  .wr_en   (wr_en),
  .err     (err),
  .rdata   (rdata),
  .run     (start_q),
  .cnt_all (cnt_all)
);

// File: tb/test_tmr_unit.sv
`timescale 1ns/1ps
module test_tmr_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_m;
  logic        err, err_m;
  logic [2:0]  irq, irq_m;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  logic [31:0] r_q, r_m;
  logic        e_q, e_m;

  logic [31:0] shadow [5];

  always #10 clk = ~clk;

  tmr_unit i_tmr_unit (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .err(err), .irq(irq)
  );

  tmr_unit #(.HAS_CH2(1'b0), .HAS_OUTCTL(1'b0)) i_tmr_unit_min (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata_m), .err(err_m), .irq(irq_m)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit w, input logic [7:0] a, input logic [31:0] d);
    wr_en = w;
    rd_en = !w;
    addr  = a;
    wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    rd_en = 1'b0;
    r_q = rdata;
    r_m = rdata_m;
    e_q = err;
    e_m = err_m;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    acc(1'b1, a, d);
  endtask

  task automatic rd(input logic [7:0] a);
    acc(1'b0, a, '0);
  endtask

  function automatic logic [31:0] exp_ctrl(input logic [31:0] v, input bit cap, input bit flag);
    logic [31:0] m;
    m = cap ? 32'hE7 : 32'h27;
    return (v & m) | (flag ? 32'h100 : 32'h0);
  endfunction

  function automatic logic [7:0] rand_addr(input int k);
    case (k)
      0: return 8'h08;
      1: return 8'h14;
      2: return 8'h20;
      3: return 8'h2C;
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {29'd0, irq}, 32'd0);
    rd(8'h08); check("R1 reload", r_q, 32'hFFFF_FFFF);
    rd(8'h0C); check("R1 count", r_q, 32'hFFFF_FFFF);
    rd(8'h10); check("R1 ctrl", r_q, 32'd0);
    check("R10 no err on valid", {31'd0, e_q}, 32'd0);
    rd(8'h04); check("R1 start", r_q, 32'd0);
    rd(8'h00); check("R1 outctl", r_q, 32'd0);
    wr(8'h24, 32'h1234);
    check("R12 rdata zero after write", r_q, 32'd0);

    // R4/R5/R7 channel 0: reload 5, count 3, sel 0, ie on
    wr(8'h08, 32'd5);
    wr(8'h10, 32'h20);
    wr(8'h0C, 32'd3);
    wr(8'h04, 32'h1);
    repeat (7) @(negedge clk);
    wr(8'h04, 32'h0);
    rd(8'h0C); check("R4 two ticks in 8 cycles", r_q, 32'd1);
    repeat (10) @(negedge clk);
    rd(8'h0C); check("R7 frozen while stopped", r_q, 32'd1);
    rd(8'h04); check("R3 start readback", r_q, 32'd0);
    wr(8'h04, 32'h1);
    repeat (7) @(negedge clk);
    wr(8'h04, 32'h0);
    rd(8'h0C); check("R5 R7 resume then reload", r_q, 32'd5);
    rd(8'h10); check("R5 flag set", r_q, 32'h120);
    check("R5 irq high", {29'd0, irq}, 32'd1);

    // R6 flag clear semantics
    wr(8'h10, 32'h120);
    rd(8'h10); check("R6 write 1 keeps flag", r_q, 32'h120);
    wr(8'h10, 32'h020);
    rd(8'h10); check("R6 write 0 clears flag", r_q, 32'h020);
    check("R6 irq low", {29'd0, irq}, 32'd0);

    // R4 prescale sel 1 on channel 1
    wr(8'h1C, 32'h01);
    wr(8'h18, 32'd2);
    wr(8'h04, 32'h2);
    repeat (31) @(negedge clk);
    wr(8'h04, 32'h0);
    rd(8'h18); check("R4 divide by 16", r_q, 32'd0);
    rd(8'h1C); check("R4 no underflow yet", r_q, 32'h01);
    wr(8'h1C, 32'h05);
    wr(8'h18, 32'd7);
    wr(8'h04, 32'h2);
    repeat (20) @(negedge clk);
    wr(8'h04, 32'h0);
    rd(8'h18); check("R4 sel 5 no ticks", r_q, 32'd7);

    // R8 capture and control masking
    wr(8'h2C, 32'hA5A5_1234);
    rd(8'h2C); check("R8 capture storage", r_q, 32'hA5A5_1234);
    wr(8'h28, 32'hFF);
    rd(8'h28); check("R8 ch2 ctrl bits", r_q, exp_ctrl(32'hFF, 1, 0));
    wr(8'h10, 32'hFF);
    rd(8'h10); check("R8 ch0 ctrl masked", r_q, exp_ctrl(32'hFF, 0, 0));
    wr(8'h10, 32'h0);
    wr(8'h28, 32'h0);

    // R9 output control
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00); check("R9 outctl one bit", r_q, 32'd1);
    check("R10 outctl absent err", {31'd0, e_m}, 32'd1);
    check("R10 outctl absent zero", r_m, 32'd0);

    // R10 bad accesses
    rd(8'h30); check("R10 unmapped err", {31'd0, e_q}, 32'd1);
    check("R10 unmapped zero", r_q, 32'd0);
    rd(8'h09); check("R10 unaligned err", {31'd0, e_q}, 32'd1);
    rd(8'h20); check("R2 ch2 reload present", {31'd0, e_q}, 32'd0);
    check("R10 ch2 absent err", {31'd0, e_m}, 32'd1);
    check("R10 ch2 absent zero", r_m, 32'd0);
    @(negedge clk);
    check("R10 err one cycle", {31'd0, err}, 32'd0);

    // R11 start bit 2 without channel 2
    wr(8'h04, 32'h7);
    check("R11 err on bit2", {31'd0, e_m}, 32'd1);
    check("R3 full unit no err", {31'd0, e_q}, 32'd0);
    wr(8'h04, 32'h0);
    wr(8'h04, 32'h7);
    rd(8'h04);
    check("R3 start readback 7", r_q, 32'h7);
    check("R11 bits 0 1 kept", r_m, 32'h3);
    wr(8'h04, 32'h0);

    // R2 random map exercise with shadow state
    shadow[0] = 32'd5;
    shadow[1] = 32'hFFFF_FFFF;
    shadow[2] = 32'hFFFF_FFFF;
    shadow[3] = 32'hA5A5_1234;
    shadow[4] = 32'd1;
    void'($urandom(32'h5EED));
    for (int it = 0; it < 150; it++) begin
      int k;
      int op;
      logic [31:0] v;
      k  = int'($urandom % 5);
      op = int'($urandom % 3);
      v  = $urandom;
      if (op == 0) begin
        wr(rand_addr(k), v);
        shadow[k] = (k == 4) ? {31'd0, v[0]} : v;
      end else if (op == 1) begin
        rd(rand_addr(k));
        check("R2 random readback", r_q, shadow[k]);
      end else begin
        logic [7:0] ba;
        ba = 8'h30 + 8'(4 * ($urandom % 52));
        rd(ba);
        check("R10 random bad offset", {r_q[30:0], e_q}, 32'd1);
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule